// File: doc/BRIEF.md
# Outbound Character Channel Reader

This block feeds a peripheral with characters taken from a character memory, one character for each device request. A start pulse gives it a first address and a set of mode bits, and the block marks itself active. Each request gets a single-cycle response one clock later. The response carries a result code and a 7-bit character, where bit 6 is the word mark and bits 5:0 are the data.

In load mode, a word-marked character cannot reach the device in one symbol. The block sends an escape character first. It keeps the character's six data bits in a one-character holding register and sends them on the following request.

A record ends in one of three ways:
- the block fetches a group mark while record-stop is enabled;
- the next address would reach the memory limit;
- the device asks for an end with a flag on its request.

There is also a command-data phase. In that phase the memory text is sent as disk command characters, masked to six bits, up to a group mark.

Top module: `ocr_reader`

## Requirements
- R1: After reset, active, done, disco and resp_valid are all 0.
- R2: A start pulse while inactive loads the address and the mode bits, sets active and clears done, disco and any held character. A start pulse while active has no effect on the address, the modes or the output stream.
- R3: A request without the end flag made while inactive is answered with code 2 (timing error). The address does not change.
- R4: When active in plain mode, a request returns code 0 (data-ok) with the 7-bit memory character at the current address. The address then advances by one. The response appears exactly one cycle after the request.
- R5: In load mode, a fetched character with bit 6 set, or equal to 035 octal (6'h1D), is sent as 7'h1D with code 0. Its low six bits are held, and the next request returns them with code 0 without reading memory.
- R6: With record-stop enabled, fetching the group mark 7'h7F returns code 1 (end-of-record). It also clears active, sets done, sets disco if dev_sel was given at start, and leaves the address one past the mark. With record-stop disabled, the group mark is sent as ordinary data.
- R7: If the current address plus one is not below MEM_DEPTH, a request returns code 1 without reading memory. The address advances by one, active clears, done keeps its value and disco follows the selected bit.
- R8: In the command-data phase, each request returns code 0 with the memory character masked to six bits and advances the address. A group mark returns code 1, leaves the address unchanged and leaves active set.
- R9: A request with req_weor set returns code 1, sets done and leaves the address and active unchanged. This takes priority over every other case, including the inactive case.
- R10: resp_valid is high for exactly the one cycle after each request. disco is never high unless dev_sel was set at the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while inactive |
| start_addr | input | AW | First memory address of the transfer |
| load_mode | input | 1 | Word marks are sent as escape plus data |
| rec_stop | input | 1 | A group mark ends the record |
| cmd_phase | input | 1 | Command-data phase: 6-bit characters up to a group mark |
| dev_sel | input | 1 | A device is selected; end conditions raise disco |
| req | input | 1 | Device request for one character |
| req_weor | input | 1 | The request asks for end-of-record |
| mem_addr | output | AW | Memory read address (current address) |
| mem_rdata | input | 7 | Memory character at mem_addr, same cycle |
| resp_valid | output | 1 | Response strobe, one cycle after req |
| resp_code | output | 2 | 0 data-ok, 1 end-of-record, 2 timing error |
| resp_data | output | 7 | Character returned with data-ok |
| active | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion status, cleared by start |
| disco | output | 1 | Disconnect request to the selected device |

## Verification
The assertions check the per-cycle rules on every cycle:
- a request answered exactly one cycle later;
- a timing error for any request made while inactive;
- an end-of-record response whenever active falls;
- six-bit data in the command phase;
- disconnect only with a selected device;
- an address that never passes the limit.

Some behaviour only the bench's scenarios can show, because it depends on memory contents and on ordering across several requests:
- the two-step escape sequence in load mode;
- where the address stops after a group mark or at the limit;
- a start ignored while active;
- the sticky done flag.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

  typedef enum logic [1:0] {
    RC_DATA_OK = 2'd0,
    RC_EOR     = 2'd1,
    RC_TIMING  = 2'd2
  } resp_code_e;

  localparam logic [6:0] GROUP_MARK = 7'h7F;
  localparam logic [5:0] ESC_CHAR   = 6'h1D;

  function automatic logic f_is_group_mark(input logic [6:0] c);
    return c == GROUP_MARK;
  endfunction

  function automatic logic f_needs_escape(input logic [6:0] c);
    return c[6] | (c[5:0] == ESC_CHAR);
  endfunction

  function automatic logic [6:0] f_low6(input logic [6:0] c);
    return {1'b0, c[5:0]};
  endfunction

endpackage

// File: rtl/ocr_classify.sv
module ocr_classify
  import ocr_pkg::*;
(
  input  logic [6:0] ch,
  output logic       is_gm,
  output logic       needs_esc,
  output logic [6:0] low6
);
  always_comb begin
    is_gm     = f_is_group_mark(ch);
    needs_esc = f_needs_escape(ch);
    low6      = f_low6(ch);
  end
endmodule

// File: rtl/ocr_limit.sv
module ocr_limit #(
  parameter int MEM_DEPTH = 64,
  parameter int AW        = $clog2(MEM_DEPTH) + 1
) (
  input  logic [AW-1:0] addr,
  output logic          past_limit,
  output logic [AW-1:0] addr_inc
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(MEM_DEPTH);

  always_comb begin
    past_limit = ({1'b0, addr} + (AW+1)'(1)) >= DEPTH_W;
    addr_inc   = addr + AW'(1);
  end
endmodule

// File: rtl/ocr_reader.sv
module ocr_reader
  import ocr_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int AW        = $clog2(MEM_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          load_mode,
  input  logic          rec_stop,
  input  logic          cmd_phase,
  input  logic          dev_sel,
  input  logic          req,
  input  logic          req_weor,
  output logic [AW-1:0] mem_addr,
  input  logic [6:0]    mem_rdata,
  output logic          resp_valid,
  output logic [1:0]    resp_code,
  output logic [6:0]    resp_data,
  output logic          active,
  output logic          done,
  output logic          disco
);

  // state
  logic [AW-1:0] addr_q;
  logic          load_q, stop_q, cmd_q, sel_q;
  logic          held_q;
  logic [6:0]    held_ch_q;

  // named internal events
  logic          ev_start, ev_weor, ev_idle_req, ev_cmd, ev_held, ev_limit;
  logic          ev_fetch, ev_gm_end;
  logic          ch_gm, ch_esc;
  logic [6:0]    ch_low6;
  logic          lim_past;
  logic [AW-1:0] addr_inc;

  ocr_classify u_cls (
    .ch       (mem_rdata),
    .is_gm    (ch_gm),
    .needs_esc(ch_esc),
    .low6     (ch_low6)
  );

  ocr_limit #(.MEM_DEPTH(MEM_DEPTH), .AW(AW)) u_lim (
    .addr      (addr_q),
    .past_limit(lim_past),
    .addr_inc  (addr_inc)
  );

  assign mem_addr    = addr_q;
  assign ev_start    = start & ~active;
  assign ev_weor     = req & req_weor;
  assign ev_idle_req = req & ~req_weor & ~active;
  assign ev_cmd      = req & ~req_weor & active & cmd_q;
  assign ev_held     = req & ~req_weor & active & ~cmd_q & load_q & held_q;
  assign ev_limit    = req & ~req_weor & active & ~cmd_q & ~(load_q & held_q) & lim_past;
  assign ev_fetch    = req & ~req_weor & active & ~cmd_q & ~(load_q & held_q) & ~lim_past;
  assign ev_gm_end   = ev_fetch & stop_q & ch_gm;

  // next-response decode
  logic [1:0] nxt_code;
  logic [6:0] nxt_data;
  always_comb begin
    nxt_code = RC_DATA_OK;
    nxt_data = 7'h00;
    if (ev_weor)          nxt_code = RC_EOR;
    else if (ev_idle_req) nxt_code = RC_TIMING;
    else if (ev_cmd) begin
      if (ch_gm) nxt_code = RC_EOR;
      else       nxt_data = ch_low6;
    end
    else if (ev_held)     nxt_data = held_ch_q;
    else if (ev_limit)    nxt_code = RC_EOR;
    else if (ev_fetch) begin
      if (ev_gm_end)               nxt_code = RC_EOR;
      else if (load_q && ch_esc)   nxt_data = {1'b0, ESC_CHAR};
      else                         nxt_data = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      load_q     <= 1'b0;
      stop_q     <= 1'b0;
      cmd_q      <= 1'b0;
      sel_q      <= 1'b0;
      held_q     <= 1'b0;
      held_ch_q  <= '0;
      active     <= 1'b0;
      done       <= 1'b0;
      disco      <= 1'b0;
      resp_valid <= 1'b0;
      resp_code  <= RC_DATA_OK;
      resp_data  <= '0;
    end else begin
      resp_valid <= req;
      if (req) begin
        resp_code <= nxt_code;
        resp_data <= nxt_data;
      end
      if (ev_start) begin
        addr_q <= start_addr;
        load_q <= load_mode;
        stop_q <= rec_stop;
        cmd_q  <= cmd_phase;
        sel_q  <= dev_sel;
        held_q <= 1'b0;
        active <= 1'b1;
        done   <= 1'b0;
        disco  <= 1'b0;
      end else if (ev_weor) begin
        done <= 1'b1;
      end else if (ev_cmd) begin
        if (!ch_gm) addr_q <= addr_inc;
      end else if (ev_held) begin
        held_q <= 1'b0;
      end else if (ev_limit) begin
        addr_q <= addr_inc;
        active <= 1'b0;
        disco  <= sel_q;
      end else if (ev_fetch) begin
        addr_q <= addr_inc;
        if (ev_gm_end) begin
          active <= 1'b0;
          done   <= 1'b1;
          disco  <= sel_q;
        end else if (load_q && ch_esc) begin
          held_q    <= 1'b1;
          held_ch_q <= ch_low6;
        end
      end
    end
  end

  // assertions
  a_r3_terr_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_weor && !active) |=> (resp_valid && resp_code == RC_TIMING));

  a_r9_weor_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_weor) |=> (done && resp_code == RC_EOR));

  a_r6_fall_is_eor: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (resp_valid && resp_code == RC_EOR));

  a_r8_cmd_six_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == RC_DATA_OK && cmd_q) |-> (resp_data[6] == 1'b0));

  a_r10_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req));

  a_r10_disco_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    disco |-> sel_q);

  a_r7_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) || $stable(active)) |-> (mem_addr <= AW'(MEM_DEPTH)));

endmodule

// File: tb/sim_ocr_reader.sv
module sim_ocr_reader;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH) + 1;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [AW-1:0] start_addr = '0;
  logic          load_mode = 0, rec_stop = 0, cmd_phase = 0, dev_sel = 0;
  logic          req = 0, req_weor = 0;
  logic [AW-1:0] mem_addr;
  logic [6:0]    mem_rdata;
  logic          resp_valid, active, done, disco;
  logic [1:0]    resp_code;
  logic [6:0]    resp_data;

  logic [6:0] mem [DEPTH];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign mem_rdata = (mem_addr < AW'(DEPTH)) ? mem[mem_addr[AW-2:0]] : 7'h00;

  ocr_reader #(.MEM_DEPTH(DEPTH), .AW(AW)) u0 (
    .clk, .rst_n, .start, .start_addr, .load_mode, .rec_stop, .cmd_phase,
    .dev_sel, .req, .req_weor, .mem_addr, .mem_rdata, .resp_valid,
    .resp_code, .resp_data, .active, .done, .disco
  );

  // load-mode stream from address 10: {code, data}
  localparam logic [8:0] LOAD_VEC [7] = '{
    {2'd0, 7'h1D}, {2'd0, 7'h01}, {2'd0, 7'h05}, {2'd0, 7'h1D},
    {2'd0, 7'h1D}, {2'd0, 7'h22}, {2'd1, 7'h00}
  };

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic do_start(input int a, input bit ld, input bit stp, input bit cmd, input bit sel);
    @(negedge clk);
    start = 1; start_addr = AW'(a); load_mode = ld; rec_stop = stp;
    cmd_phase = cmd; dev_sel = sel;
    @(negedge clk);
    start = 0;
  endtask

  task automatic do_req(input bit weor);
    @(negedge clk);
    req = 1; req_weor = weor;
    @(negedge clk);
    req = 0; req_weor = 0;
  endtask

  task automatic expect_resp(input string tag, input int code, input int data);
    chk(tag, resp_valid, 1);
    chk(tag, resp_code, code);
    if (code == 0) chk(tag, resp_data, data);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 7'h00;
    mem[10] = 7'h41; mem[11] = 7'h05; mem[12] = 7'h1D; mem[13] = 7'h22; mem[14] = 7'h7F;
    mem[20] = 7'h43; mem[21] = 7'h12; mem[22] = 7'h7F;
    mem[61] = 7'h01; mem[62] = 7'h02; mem[63] = 7'h03;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", active, 0); chk("R1 done", done, 0);
    chk("R1 disco", disco, 0); chk("R1 valid", resp_valid, 0);
    rst_n = 1;

    // R3 idle request
    do_req(0);
    expect_resp("R3 idle", 2, 0);
    @(negedge clk);
    chk("R10 valid one cycle", resp_valid, 0);

    // R5 load mode via vector table
    do_start(10, 1, 1, 0, 1);
    chk("R2 active after start", active, 1);
    foreach (LOAD_VEC[i]) begin
      do_req(0);
      expect_resp("R5 load stream", int'(LOAD_VEC[i][8:7]), int'(LOAD_VEC[i][6:0]));
    end
    chk("R6 active cleared", active, 0);
    chk("R6 done set", done, 1);
    chk("R6 disco with sel", disco, 1);
    chk("R6 addr past mark", mem_addr, 15);
    do_req(0);
    expect_resp("R3 after end", 2, 0);

    // R4 plain mode, R2 start ignored while active
    do_start(10, 0, 1, 0, 0);
    chk("R2 done cleared", done, 0);
    chk("R2 disco cleared", disco, 0);
    do_req(0); expect_resp("R4 plain wm char", 0, 7'h41);
    do_start(20, 1, 0, 1, 1);
    do_req(0); expect_resp("R2 start ignored", 0, 7'h05);
    do_req(0); expect_resp("R4 plain 035", 0, 7'h1D);
    // R9 weor mid-record
    do_req(1);
    expect_resp("R9 weor", 1, 0);
    chk("R9 done", done, 1); chk("R9 active kept", active, 1);
    chk("R9 addr kept", mem_addr, 13);
    do_req(0); expect_resp("R4 after weor", 0, 7'h22);
    do_req(0); expect_resp("R6 gm end", 1, 0);
    chk("R10 no disco without sel", disco, 0);

    // R6 record-stop off: group mark is data
    do_start(14, 0, 0, 0, 0);
    do_req(0); expect_resp("R6 gm as data", 0, 7'h7F);
    chk("R6 still active", active, 1);

    // R9 weor while inactive has priority
    rst_n = 0; @(negedge clk); rst_n = 1;
    do_req(1); expect_resp("R9 weor idle", 1, 0);
    chk("R9 done idle", done, 1);

    // R8 command phase
    do_start(20, 1, 1, 1, 0);
    do_req(0); expect_resp("R8 cmd masked", 0, 7'h03);
    do_req(0); expect_resp("R8 cmd char", 0, 7'h12);
    do_req(0); expect_resp("R8 cmd gm", 1, 0);
    do_req(0); expect_resp("R8 cmd gm again", 1, 0);
    chk("R8 addr not advanced", mem_addr, 22);
    chk("R8 active kept", active, 1);

    // R7 memory limit
    rst_n = 0; @(negedge clk); rst_n = 1;
    do_start(61, 0, 0, 0, 1);
    do_req(0); expect_resp("R7 before limit", 0, 7'h01);
    do_req(0); expect_resp("R7 last readable", 0, 7'h02);
    do_req(0); expect_resp("R7 limit eor", 1, 0);
    chk("R7 active cleared", active, 0);
    chk("R7 done unchanged", done, 0);
    chk("R7 addr incremented", mem_addr, 64);
    chk("R7 disco with sel", disco, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule